// File: doc/BRIEF.md
# OFDM Cyclic Prefix and Edge-Window Overlap Inserter

This block sits after an inverse FFT. It takes each time-domain OFDM symbol as a stream of complex samples and turns it into the transmit sample stream. The symbol is first stored whole in an internal buffer. The block then plays out a cyclic prefix, which is a copy of the last samples of the symbol, followed by the symbol body. The prefix is longer on the first symbol of every seven-symbol slot than on the other six.

Symbol edges are softened by weighted overlap-add. The first samples of every emitted symbol are scaled by a raised-cosine ramp-up. The first samples of the previous symbol serve as its cyclic extension past the end, and they are scaled by the matching ramp-down and added in. Consecutive symbols therefore stay spaced by prefix plus symbol size.

Two configurations can be chosen at run time. The short configuration uses 512-sample symbols, prefixes of 40 and 36 samples, and a 4-sample window. The long configuration uses 1024-sample symbols, prefixes of 80 and 72 samples, and a 6-sample window. A new configuration takes effect only where a slot begins.

The controller is a three-state machine:
- `ST_LOAD` accepts samples into the buffer. It moves to `ST_PREFIX` when the last sample of the symbol is accepted.
- `ST_PREFIX` emits the prefix, including the blended window region. It moves to `ST_BODY` when the last prefix sample is taken.
- `ST_BODY` emits the stored body. It returns to `ST_LOAD` when the last body sample is taken, and at that point the slot position advances, wrapping after seven symbols.

Top module: `cpw_inserter`

## Requirements
- R1: While reset is asserted and right after it is released, `in_ready` is 1 and `out_valid` is 0. The slot position is 0, the configuration is the short one and the stored window tail is zero.
- R2: With `mode_sel`=0 the block accepts exactly 512 samples per symbol before any output, and with `mode_sel`=1 it accepts exactly 1024. `out_valid` stays 0 until the last one is accepted.
- R3: Each symbol produces exactly prefix-plus-size output samples. The prefix is 40 (short) or 80 (long) at slot position 0, and 36 or 72 at every other position. Afterwards `out_valid` returns to 0 and `in_ready` to 1.
- R4: Output sample j with W <= j < P equals input sample N-P+j. Output sample j >= P equals input sample j-P. Here P is the prefix length, N the symbol size and W the window length (4 short, 6 long). Samples are two's-complement, 16 bits per component.
- R5: Output sample j < W equals (u[j]*x[N-P+j] + u[W-1-j]*t[j] + 16384) >> 15, arithmetic shift, for each component. Here t is the first W samples of the previous symbol. The Q15 ramp-up weights u are 1247, 10114, 22654, 31521 for the short configuration and 558, 4799, 12143, 20625, 27969, 32210 for the long one.
- R6: After reset, and on the first symbol after a configuration change, t is all zero.
- R7: Each ramp-up/ramp-down weight pair sums to 32768. A constant input held across two symbols of one configuration therefore comes out unchanged in the blended region.
- R8: Symbols are counted in slots of 7. Slot position 0 recurs every seventh symbol and after reset.
- R9: `mode_sel` is sampled only when a slot is about to begin, before its first sample is accepted. A change requested mid-slot takes effect on the next slot.
- R10: `in_ready` is 0 for the whole time the prefix and body are played out. It only falls after an accepted input sample.
- R11: While `out_valid` is 1 and `out_ready` is 0, the output sample is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 1 | Requested configuration: 0 short, 1 long |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept an input sample |
| in_re | input | 16 | Input sample, real part |
| in_im | input | 16 | Input sample, imaginary part |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_re | output | 16 | Output sample, real part |
| out_im | output | 16 | Output sample, imaginary part |

## Verification
Symbols are fed from four patterns. A linear ramp shows up prefix source-address errors. An alternating sign pattern shows up off-by-one tail selection. A quadratic hash pattern makes every sample unique, so a wrong weight or a wrong tail slot changes the result. A constant pattern separates correct unity-gain blending from a ramp that leaks amplitude.

The sequence runs a full short slot, a full long slot, and then a short slot again. Configuration requests are raised mid-slot to show that they are deferred. Two symbols are played against an alternating `out_ready` so that held outputs can be compared. A reset in the middle of a load shows that the slot position restarts.

// File: rtl/cpw_pkg.sv
package cpw_pkg;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_PREFIX = 2'd1,
        ST_BODY   = 2'd2
    } cpw_state_e;

    localparam int WIN_FRAC = 15;
    localparam int COEF_W   = 18;
    localparam int WIN_MAX  = 6;
    localparam int WIN_IW   = 3;
    localparam logic signed [COEF_W-1:0] WIN_ONE = 18'sd32768;

    function automatic logic [WIN_IW-1:0] win_len(input logic long_cfg);
        return long_cfg ? 3'd6 : 3'd4;
    endfunction

    // Raised-cosine ramp-up weights, Q15.
    function automatic logic signed [COEF_W-1:0] win_up(input logic long_cfg,
                                                        input logic [WIN_IW-1:0] i);
        logic signed [COEF_W-1:0] c;
        c = '0;
        if (!long_cfg) begin
            case (i)
                3'd0: c = 18'sd1247;
                3'd1: c = 18'sd10114;
                3'd2: c = 18'sd22654;
                3'd3: c = 18'sd31521;
                default: c = '0;
            endcase
        end else begin
            case (i)
                3'd0: c = 18'sd558;
                3'd1: c = 18'sd4799;
                3'd2: c = 18'sd12143;
                3'd3: c = 18'sd20625;
                3'd4: c = 18'sd27969;
                3'd5: c = 18'sd32210;
                default: c = '0;
            endcase
        end
        return c;
    endfunction

    // Matching ramp-down weights, Q15.
    function automatic logic signed [COEF_W-1:0] win_dn(input logic long_cfg,
                                                        input logic [WIN_IW-1:0] i);
        logic signed [COEF_W-1:0] c;
        c = '0;
        if (!long_cfg) begin
            case (i)
                3'd0: c = 18'sd31521;
                3'd1: c = 18'sd22654;
                3'd2: c = 18'sd10114;
                3'd3: c = 18'sd1247;
                default: c = '0;
            endcase
        end else begin
            case (i)
                3'd0: c = 18'sd32210;
                3'd1: c = 18'sd27969;
                3'd2: c = 18'sd20625;
                3'd3: c = 18'sd12143;
                3'd4: c = 18'sd4799;
                3'd5: c = 18'sd558;
                default: c = '0;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/cpw_ctrl.sv
module cpw_ctrl
    import cpw_pkg::*;
#(
    parameter int N_A      = 512,
    parameter int N_B      = 1024,
    parameter int CPL_A    = 40,
    parameter int CPS_A    = 36,
    parameter int CPL_B    = 80,
    parameter int CPS_B    = 72,
    parameter int SLOT_LEN = 7,
    localparam int DEPTH   = (N_A > N_B) ? N_A : N_B,
    localparam int AW      = $clog2(DEPTH),
    localparam int SW      = $clog2(SLOT_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              in_valid,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              out_valid,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [AW-1:0]     rd_addr,
    output logic              mode,
    output logic              blend_en,
    output logic              tail_cap,
    output logic              tail_clr,
    output logic [WIN_IW-1:0] win_idx
);

    localparam logic [AW-1:0] LAST_A    = AW'(N_A - 1);
    localparam logic [AW-1:0] LAST_B    = AW'(N_B - 1);
    localparam logic [AW-1:0] CPL_A_V   = AW'(CPL_A);
    localparam logic [AW-1:0] CPS_A_V   = AW'(CPS_A);
    localparam logic [AW-1:0] CPL_B_V   = AW'(CPL_B);
    localparam logic [AW-1:0] CPS_B_V   = AW'(CPS_B);
    localparam logic [AW-1:0] ONE_A     = AW'(1);
    localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT_LEN - 1);
    localparam logic [SW-1:0] ONE_S     = SW'(1);

    cpw_state_e        st_q, st_d;
    logic [AW-1:0]     idx_q, idx_d;
    logic [SW-1:0]     pos_q, pos_d;
    logic              mode_q, mode_d;
    logic [AW-1:0]     n_last, cp_len;
    logic [WIN_IW-1:0] w_len;

    // Per-symbol geometry from the active configuration and slot position.
    always_comb begin
        n_last = mode_q ? LAST_B : LAST_A;
        if (pos_q == '0) begin
            cp_len = mode_q ? CPL_B_V : CPL_A_V;
        end else begin
            cp_len = mode_q ? CPS_B_V : CPS_A_V;
        end
        w_len = win_len(mode_q);
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_LOAD;
            idx_q  <= '0;
            pos_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            idx_q  <= idx_d;
            pos_q  <= pos_d;
            mode_q <= mode_d;
        end
    end

    // Next state and counters.
    always_comb begin
        st_d   = st_q;
        idx_d  = idx_q;
        pos_d  = pos_q;
        mode_d = mode_q;
        unique case (st_q)
            ST_LOAD: begin
                if (idx_q == '0 && pos_q == '0) begin
                    mode_d = mode_sel;
                end
                if (in_valid) begin
                    if (idx_q == n_last) begin
                        st_d  = ST_PREFIX;
                        idx_d = '0;
                    end else begin
                        idx_d = idx_q + ONE_A;
                    end
                end
            end
            ST_PREFIX: begin
                if (out_ready) begin
                    if (idx_q == cp_len - ONE_A) begin
                        st_d  = ST_BODY;
                        idx_d = '0;
                    end else begin
                        idx_d = idx_q + ONE_A;
                    end
                end
            end
            ST_BODY: begin
                if (out_ready) begin
                    if (idx_q == n_last) begin
                        st_d  = ST_LOAD;
                        idx_d = '0;
                        pos_d = (pos_q == SLOT_LAST) ? '0 : pos_q + ONE_S;
                    end else begin
                        idx_d = idx_q + ONE_A;
                    end
                end
            end
            default: st_d = ST_LOAD;
        endcase
    end

    // Outputs.
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        wr_en     = 1'b0;
        blend_en  = 1'b0;
        tail_cap  = 1'b0;
        tail_clr  = 1'b0;
        rd_addr   = idx_q;
        unique case (st_q)
            ST_LOAD: begin
                in_ready = 1'b1;
                wr_en    = in_valid;
                tail_clr = (idx_q == '0) && (pos_q == '0) && (mode_sel != mode_q);
            end
            ST_PREFIX: begin
                out_valid = 1'b1;
                rd_addr   = n_last - cp_len + ONE_A + idx_q;
                blend_en  = idx_q < AW'(w_len);
            end
            ST_BODY: begin
                out_valid = 1'b1;
                tail_cap  = out_ready && (idx_q < AW'(w_len));
            end
            default: ;
        endcase
    end

    assign wr_addr = idx_q;
    assign mode    = mode_q;
    assign win_idx = idx_q[WIN_IW-1:0];

    // Independent count of samples taken in the current symbol.
    localparam logic [AW:0] ONE_E = (AW+1)'(1);
    logic [AW:0] emitted_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            emitted_q <= '0;
        end else if (st_q == ST_LOAD) begin
            emitted_q <= '0;
        end else if (out_ready) begin
            emitted_q <= emitted_q + ONE_E;
        end
    end

    // R3
    sym_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BODY && out_ready && idx_q == n_last)
        |-> (emitted_q == ({1'b0, cp_len} + {1'b0, n_last})));

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q))
        |-> $past(st_q == ST_LOAD && idx_q == '0 && pos_q == '0));

    // R8
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= SLOT_LAST);

    // R10
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> $past(in_valid));

endmodule

// File: rtl/cpw_buf.sv
module cpw_buf
    import cpw_pkg::*;
#(
    parameter int DW     = 16,
    parameter int DEPTH  = 1024,
    localparam int AW    = $clog2(DEPTH),
    localparam int SW2   = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [SW2-1:0]    wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [SW2-1:0]    rd_data,
    input  logic              tail_cap,
    input  logic              tail_clr,
    input  logic [WIN_IW-1:0] tail_idx,
    output logic [SW2-1:0]    tail_data
);

    logic [SW2-1:0] mem [DEPTH];
    logic [SW2-1:0] tail_q [WIN_MAX];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    // Head samples of the last played symbol, kept for the next overlap.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN_MAX; i++) tail_q[i] <= '0;
        end else if (tail_clr) begin
            for (int i = 0; i < WIN_MAX; i++) tail_q[i] <= '0;
        end else if (tail_cap) begin
            tail_q[tail_idx] <= rd_data;
        end
    end

    assign tail_data = (tail_idx < WIN_IW'(WIN_MAX)) ? tail_q[tail_idx] : '0;

    generate
        for (genvar g = 0; g < WIN_MAX; g++) begin : g_tail_chk
            // R6
            tail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tail_clr |=> (tail_q[g] == '0));
        end
    endgenerate

endmodule

// File: rtl/cpw_window.sv
module cpw_window
    import cpw_pkg::*;
#(
    parameter int DW     = 16,
    localparam int SW2   = 2 * DW,
    localparam int ACC_W = DW + COEF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,
    input  logic              en,
    input  logic [WIN_IW-1:0] idx,
    input  logic [SW2-1:0]    cur,
    input  logic [SW2-1:0]    prev,
    output logic [SW2-1:0]    res
);

    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (WIN_FRAC - 1);

    logic signed [COEF_W-1:0] c_up, c_dn;
    logic signed [ACC_W-1:0]  cu, cd, cr, ci, pr, pi;
    logic signed [ACC_W-1:0]  acc_re, acc_im;
    logic                     unused_acc;

    always_comb begin
        c_up   = win_up(mode, idx);
        c_dn   = win_dn(mode, idx);
        cu     = ACC_W'(c_up);
        cd     = ACC_W'(c_dn);
        cr     = ACC_W'($signed(cur[DW-1:0]));
        ci     = ACC_W'($signed(cur[SW2-1:DW]));
        pr     = ACC_W'($signed(prev[DW-1:0]));
        pi     = ACC_W'($signed(prev[SW2-1:DW]));
        acc_re = cr * cu + pr * cd + HALF;
        acc_im = ci * cu + pi * cd + HALF;
        if (en) begin
            res = {acc_im[WIN_FRAC +: DW], acc_re[WIN_FRAC +: DW]};
        end else begin
            res = cur;
        end
    end

    assign unused_acc = ^{acc_re[WIN_FRAC-1:0], acc_re[ACC_W-1:WIN_FRAC+DW],
                          acc_im[WIN_FRAC-1:0], acc_im[ACC_W-1:WIN_FRAC+DW]};

    // R7
    unity_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> ((c_up + c_dn) == WIN_ONE));

endmodule

// File: rtl/cpw_inserter.sv
module cpw_inserter
    import cpw_pkg::*;
#(
    parameter int DW       = 16,
    parameter int N_A      = 512,
    parameter int N_B      = 1024,
    parameter int CPL_A    = 40,
    parameter int CPS_A    = 36,
    parameter int CPL_B    = 80,
    parameter int CPS_B    = 72,
    parameter int SLOT_LEN = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sel,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_re,
    input  logic [DW-1:0] in_im,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_re,
    output logic [DW-1:0] out_im
);

    localparam int DEPTH = (N_A > N_B) ? N_A : N_B;
    localparam int AW    = $clog2(DEPTH);
    localparam int SW2   = 2 * DW;

    logic              wr_en, mode, blend_en, tail_cap, tail_clr;
    logic [AW-1:0]     wr_addr, rd_addr;
    logic [WIN_IW-1:0] win_idx;
    logic [SW2-1:0]    rd_data, tail_data, res;

    cpw_ctrl #(
        .N_A(N_A), .N_B(N_B), .CPL_A(CPL_A), .CPS_A(CPS_A),
        .CPL_B(CPL_B), .CPS_B(CPS_B), .SLOT_LEN(SLOT_LEN)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .in_valid(in_valid), .out_ready(out_ready),
        .in_ready(in_ready), .out_valid(out_valid),
        .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .mode(mode), .blend_en(blend_en), .tail_cap(tail_cap),
        .tail_clr(tail_clr), .win_idx(win_idx)
    );

    cpw_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data({in_im, in_re}),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .tail_cap(tail_cap), .tail_clr(tail_clr), .tail_idx(win_idx),
        .tail_data(tail_data)
    );

    cpw_window #(.DW(DW)) u_win (
        .clk(clk), .rst_n(rst_n), .mode(mode), .en(blend_en), .idx(win_idx),
        .cur(rd_data), .prev(tail_data), .res(res)
    );

    assign out_re = res[DW-1:0];
    assign out_im = res[SW2-1:DW];

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));

endmodule

// File: tb/cpw_inserter_tb.sv
module cpw_inserter_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_sel;
    logic        in_valid;
    logic        in_ready;
    logic [15:0] in_re, in_im;
    logic        out_valid;
    logic        out_ready;
    logic [15:0] out_re, out_im;

    always #4 clk = ~clk;

    cpw_inserter u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re), .out_im(out_im)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // columns: mode_sel, pattern, expected config, expected prefix, stall
    localparam int ROWS = 16;
    localparam int TBL [ROWS][5] = '{
        '{0, 0, 0, 40, 0}, '{0, 1, 0, 36, 1}, '{1, 2, 0, 36, 0}, '{1, 0, 0, 36, 0},
        '{1, 2, 0, 36, 0}, '{1, 1, 0, 36, 0}, '{1, 0, 0, 36, 0}, '{1, 2, 1, 80, 0},
        '{1, 0, 1, 72, 1}, '{0, 1, 1, 72, 0}, '{0, 2, 1, 72, 0}, '{0, 0, 1, 72, 0},
        '{0, 1, 1, 72, 0}, '{0, 2, 1, 72, 0}, '{0, 3, 0, 40, 0}, '{0, 3, 0, 36, 0}
    };

    int xr [1024];
    int xi [1024];
    int tr [6];
    int ti [6];
    int prev_cfg = -1;

    function automatic int upw(input int cfg, input int i);
        int t0 [4] = '{1247, 10114, 22654, 31521};
        int t1 [6] = '{558, 4799, 12143, 20625, 27969, 32210};
        return (cfg != 0) ? t1[i] : t0[i];
    endfunction

    function automatic int gre(input int pat, input int s, input int k);
        case (pat)
            0: return ((k * 37 + s * 101) % 30001) - 15000;
            1: return (((k % 2) == 1) ? 9000 : -9000) + s;
            2: return ((k * k * 13 + s * 7) % 32000) - 16000;
            default: return 12345;
        endcase
    endfunction

    function automatic int gim(input int pat, input int s, input int k);
        case (pat)
            0: return 15000 - ((k * 53) % 30001);
            1: return (k % 7) * 1000 - 3000;
            2: return (((k * 29) ^ (s * 5)) % 20000) - 10000;
            default: return -2345;
        endcase
    endfunction

    task automatic run_symbol(input int row, input bit sel, input int pat,
                              input int cfg, input int cp, input bit stall);
        int n;
        int w;
        int j;
        bit held;
        bit tgl;
        bit rdy_bad;
        logic [15:0] hr, hi;
        string lreq;
        n = (cfg != 0) ? 1024 : 512;
        w = (cfg != 0) ? 6 : 4;
        mode_sel = sel;
        if (cfg != prev_cfg) begin
            for (int k = 0; k < 6; k++) begin
                tr[k] = 0;
                ti[k] = 0;
            end
        end
        prev_cfg = cfg;
        for (int k = 0; k < n; k++) begin
            xr[k] = gre(pat, row, k);
            xi[k] = gim(pat, row, k);
        end
        // load phase
        for (int k = 0; k < n; k++) begin
            in_re    = 16'(xr[k]);
            in_im    = 16'(xi[k]);
            in_valid = 1'b1;
            while (!in_ready) @(negedge clk);
            if (k == n - 1) begin
                // R2: last sample still accepted, nothing emitted yet
                chk(in_ready && !out_valid, "R2", {in_ready, out_valid}, 2);
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        // R2: full symbol taken, playout begins
        chk(!in_ready && out_valid, "R2", {in_ready, out_valid}, 1);
        // playout
        j       = 0;
        held    = 1'b0;
        tgl     = 1'b0;
        rdy_bad = 1'b0;
        hr      = '0;
        hi      = '0;
        while (j < cp + n) begin
            tgl       = ~tgl;
            out_ready = stall ? tgl : 1'b1;
            if (held) begin
                chk(out_valid && out_re == hr && out_im == hi, "R11",
                    {out_re, out_im}, {hr, hi});
                held = 1'b0;
            end
            if (in_ready) rdy_bad = 1'b1;
            if (out_valid && out_ready) begin
                int src;
                int er;
                int ei;
                string req;
                src = (j < cp) ? (n - cp + j) : (j - cp);
                er  = xr[src];
                ei  = xi[src];
                req = (j < cp) ? "R4 prefix" : "R4 body";
                if (j < w) begin
                    longint ar;
                    longint ai;
                    int u;
                    int d;
                    u   = upw(cfg, j);
                    d   = upw(cfg, w - 1 - j);
                    ar  = longint'(u) * xr[src] + longint'(d) * tr[j] + 16384;
                    ai  = longint'(u) * xi[src] + longint'(d) * ti[j] + 16384;
                    er  = int'(ar >>> 15);
                    ei  = int'(ai >>> 15);
                    req = (tr[j] == 0 && ti[j] == 0) ? "R6" : "R5";
                    if (row == 15) begin
                        // R7: flat input stays flat across the overlap
                        chk(int'($signed(out_re)) == 12345, "R7", $signed(out_re), 12345);
                    end
                end
                chk(int'($signed(out_re)) == er && int'($signed(out_im)) == ei, req,
                    $signed(out_re) * 65536 + $signed(out_im), er * 65536 + ei);
                j++;
            end else if (out_valid) begin
                held = 1'b1;
                hr   = out_re;
                hi   = out_im;
            end
            @(negedge clk);
        end
        out_ready = 1'b1;
        if (row == 2 || row == 9) lreq = "R9";
        else if ((row % 7) == 0) lreq = "R8";
        else lreq = "R3";
        // symbol length and prefix length for this slot position
        chk(!out_valid && in_ready, lreq, {out_valid, in_ready}, 1);
        // R10: no input acceptance during playout
        chk(!rdy_bad, "R10", rdy_bad, 0);
        for (int k = 0; k < w; k++) begin
            tr[k] = xr[k];
            ti[k] = xi[k];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        mode_sel  = 1'b0;
        in_valid  = 1'b0;
        in_re     = '0;
        in_im     = '0;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(in_ready && !out_valid, "R1", {in_ready, out_valid}, 2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !out_valid, "R1", {in_ready, out_valid}, 2);

        for (int r = 0; r < ROWS; r++) begin
            run_symbol(r, TBL[r][0] != 0, TBL[r][1], TBL[r][2], TBL[r][3], TBL[r][4] != 0);
        end

        // Directed: reset in the middle of a load restarts the slot.
        mode_sel = 1'b0;
        for (int k = 0; k < 100; k++) begin
            in_re    = 16'(k);
            in_im    = 16'(-k);
            in_valid = 1'b1;
            @(negedge clk);
        end
        in_valid = 1'b0;
        rst_n    = 1'b0;
        repeat (2) @(negedge clk);
        // R1: reset mid-load
        chk(in_ready && !out_valid, "R1", {in_ready, out_valid}, 2);
        rst_n = 1'b1;
        @(negedge clk);
        prev_cfg = -1;
        // R8: slot position back at 0, so the long prefix returns
        run_symbol(0, 1'b0, 2, 0, 40, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule